// File: doc/BRIEF.md
# Priority-Chained Slot Enumerator

This block is the slave front end of one module on a shared expansion bus. At boot the host cannot yet tell modules apart. A priority line runs through every slot in turn, so only one module at a time is allowed to answer the configuration address. While its incoming priority line is high and it has not been configured, the module answers an I/O read of address 0000h with a fixed type code. It then takes the I/O base byte that the host writes to that same address. After that it raises its outgoing priority line, which lets the next module in the chain be enumerated.

Once configured, the module answers only I/O cycles inside its own 256-byte window, and every such cycle is acknowledged. At one offset of that window sits a small register that selects which megabyte of the 24-bit memory space maps the module's boot ROM. Memory reads that fall in that megabyte return ROM words. Memory writes are never accepted. Dropping the incoming priority line, or a reset, puts the module back into the unconfigured state.

Bus strobes are single-cycle, active-high pulses that the block samples on the clock. The acknowledge and the read data are registered outputs and appear one clock after the strobe. The ROM array sits outside the block: the block supplies a word address and takes back the word combinationally.

Top module: `chain_slot_decoder`

## Requirements
- R1: After reset, prioOut, ack and rdData are all 0.
- R2: While prioIn is 0, prioOut is 0 in the same cycle and no cycle is acknowledged. Any captured base is lost, so after prioIn returns to 1 the old window no longer answers and address 0000h answers the type code again.
- R3: While prioIn is 1 and the module is unconfigured, an I/O read of address 0000h makes rdData equal ID_CODE, with ack set, in the cycle after the strobe.
- R4: While prioIn is 1 and the module is unconfigured, an I/O write of address 0000h is acknowledged, captures wrData[7:0] as the window's upper address byte, and sets prioOut to 1 by the cycle after the strobe.
- R5: Once configured, an I/O cycle is acknowledged only when addr[15:8] equals the captured byte, and address 0000h no longer answers the type code (when the byte is not 00h).
- R6: The memory-base register sits at window offset 20h. An I/O write stores wrData[3:0]. An I/O read returns it in rdData[3:0], with rdData[15:4] = 0.
- R7: Once configured, a memory read with addr[23:20] equal to the memory-base register is acknowledged and returns the ROM word at word address addr[12:1]. A memory read in any other megabyte is not acknowledged.
- R8: Memory writes are never acknowledged and change no state.
- R9: ack is a one-cycle pulse for each decoded strobe. Idle or undecoded cycles give ack = 0 and rdData = 0. Reads of window offsets other than 20h return 0.
- R10: Before configuration, memory reads and I/O cycles at addresses other than 0000h are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| prioIn | input | 1 | Priority grant from the upstream slot |
| prioOut | output | 1 | Priority grant to the downstream slot |
| ioRd | input | 1 | I/O read strobe, one cycle |
| ioWr | input | 1 | I/O write strobe, one cycle |
| memRd | input | 1 | Memory read strobe, one cycle |
| memWr | input | 1 | Memory write strobe, one cycle |
| addr | input | 24 | Bus address; the I/O space uses bits 15:0 |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Registered read data, valid while ack is set |
| ack | output | 1 | Registered acknowledge pulse |
| romAddr | output | 12 | Word address to the boot ROM |
| romData | input | 16 | Word returned by the boot ROM |

## Verification
The bench probes the unconfigured state with memory reads in megabyte 0 and with I/O reads inside what will later be the window. A decoder that does not gate on configuration would acknowledge these. After configuration it reads 0000h again and an adjacent window, which catches a design that keeps answering the type code or decodes too few address bits. A one-cycle drop of the priority line followed by a read of the old window exposes a base register that survives loss of priority. Memory writes into the mapped megabyte, followed by a read of the register, catch a design that acknowledges writes or lets them alter the map.

// File: rtl/slot_enum_pkg.sv
package slot_enum_pkg;

  // One-cycle strobes from the decode control to the datapath.
  typedef struct packed {
    logic clrCfg;    // priority lost: drop base and map
    logic baseLoad;  // capture window byte
    logic idRead;    // return type code
    logic regRead;   // return memory-base register
    logic regWrite;  // load memory-base register
    logic romRead;   // return ROM word
  } slotStrobe_t;

endpackage

// File: rtl/slot_enum_ctl.sv
module slot_enum_ctl
  import slot_enum_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int IO_W    = 16,
  parameter int OFF_W   = 8,
  parameter int MB_W    = 4,
  parameter int ROM_AW  = 12,
  parameter logic [OFF_W-1:0] REG_OFF = 8'h20
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    prioIn,
  input  logic                    ioRd,
  input  logic                    ioWr,
  input  logic                    memRd,
  input  logic                    memWr,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [IO_W-OFF_W-1:0]   baseByte,
  input  logic [MB_W-1:0]         memBase,
  output slotStrobe_t             st,
  output logic                    prioOut,
  output logic                    ack,
  output logic [ROM_AW-1:0]       romAddr
);
  localparam int BASE_W = IO_W - OFF_W;

  logic cfgDone;
  logic unconf, live, cfgAddr, winHit, regSel, memHit, ackNext;
  logic [IO_W-1:0] ioAddr;
  logic unusedCtl;

  assign ioAddr    = addr[IO_W-1:0];
  assign unusedCtl = ^{addr, memWr};
  assign unconf    = prioIn && !cfgDone;
  assign live      = prioIn && cfgDone;
  assign cfgAddr   = (ioAddr == '0);
  assign winHit    = live && (ioAddr[IO_W-1 -: BASE_W] == baseByte);
  assign regSel    = (ioAddr[OFF_W-1:0] == REG_OFF);
  assign memHit    = live && (addr[ADDR_W-1 -: MB_W] == memBase);

  always_comb begin
    st          = '0;
    st.clrCfg   = !prioIn;
    st.idRead   = unconf && ioRd && cfgAddr;
    st.baseLoad = unconf && ioWr && cfgAddr;
    st.regRead  = winHit && ioRd && regSel;
    st.regWrite = winHit && ioWr && regSel;
    st.romRead  = memHit && memRd;
  end

  assign ackNext = st.idRead || st.baseLoad || st.romRead ||
                   (winHit && (ioRd || ioWr));
  assign romAddr = addr[ROM_AW:1];
  assign prioOut = prioIn && cfgDone;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgDone <= 1'b0;
      ack     <= 1'b0;
    end else begin
      ack <= ackNext;
      if (!prioIn)          cfgDone <= 1'b0;
      else if (st.baseLoad) cfgDone <= 1'b1;
    end
  end

  // R4: priority is only ever released by a configuration write
  p_release_after_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(prioOut) |-> $past(ioWr && addr[IO_W-1:0] == '0));

  // R8: a lone memory write never earns an acknowledge
  p_mem_write_silent_r8: assert property (@(posedge clk) disable iff (!rstN)
    (memWr && !memRd && !ioRd && !ioWr) |=> !ack);

  // R2: losing priority leaves the module unconfigured
  p_prio_loss_r2: assert property (@(posedge clk) disable iff (!rstN)
    !prioIn |=> !cfgDone);

endmodule

// File: rtl/slot_enum_dp.sv
module slot_enum_dp
  import slot_enum_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int BASE_W  = 8,
  parameter int MB_W    = 4,
  parameter logic [DATA_W-1:0] ID_CODE = 16'h0A5C
) (
  input  logic               clk,
  input  logic               rstN,
  input  slotStrobe_t        st,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [DATA_W-1:0]  romData,
  output logic [BASE_W-1:0]  baseByte,
  output logic [MB_W-1:0]    memBase,
  output logic [DATA_W-1:0]  rdData
);
  logic [DATA_W-1:0] rdNext;
  logic unusedDp;

  assign unusedDp = ^wrData;

  always_comb begin
    rdNext = '0;
    if (st.idRead)       rdNext = ID_CODE;
    else if (st.regRead) rdNext = {{(DATA_W-MB_W){1'b0}}, memBase};
    else if (st.romRead) rdNext = romData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseByte <= '0;
      memBase  <= '0;
      rdData   <= '0;
    end else begin
      rdData <= rdNext;
      if (st.clrCfg) begin
        baseByte <= '0;
        memBase  <= '0;
      end else begin
        if (st.baseLoad) baseByte <= wrData[BASE_W-1:0];
        if (st.regWrite) memBase  <= wrData[MB_W-1:0];
      end
    end
  end

  // R4: the window byte comes from the low data byte of the config write
  p_base_capture_r4: assert property (@(posedge clk) disable iff (!rstN)
    st.baseLoad |=> baseByte == $past(wrData[BASE_W-1:0]));

  // R2: priority loss wipes the window and the ROM map
  p_clear_on_loss_r2: assert property (@(posedge clk) disable iff (!rstN)
    st.clrCfg |=> (baseByte == '0) && (memBase == '0));

  // R7: a ROM hit returns the word presented by the ROM
  p_rom_data_r7: assert property (@(posedge clk) disable iff (!rstN)
    st.romRead |=> rdData == $past(romData));

endmodule

// File: rtl/chain_slot_decoder.sv
module chain_slot_decoder
  import slot_enum_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 16,
  parameter int ROM_AW  = 12,
  parameter logic [DATA_W-1:0] ID_CODE = 16'h0A5C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              prioIn,
  output logic              prioOut,
  input  logic              ioRd,
  input  logic              ioWr,
  input  logic              memRd,
  input  logic              memWr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              ack,
  output logic [ROM_AW-1:0] romAddr,
  input  logic [DATA_W-1:0] romData
);
  localparam int IO_W   = 16;
  localparam int OFF_W  = 8;
  localparam int BASE_W = IO_W - OFF_W;
  localparam int MB_W   = 4;

  slotStrobe_t       st;
  logic [BASE_W-1:0] baseByte;
  logic [MB_W-1:0]   memBase;

  slot_enum_ctl #(
    .ADDR_W(ADDR_W), .IO_W(IO_W), .OFF_W(OFF_W), .MB_W(MB_W),
    .ROM_AW(ROM_AW), .REG_OFF(8'h20)
  ) ctl_i (
    .clk(clk), .rstN(rstN), .prioIn(prioIn),
    .ioRd(ioRd), .ioWr(ioWr), .memRd(memRd), .memWr(memWr),
    .addr(addr), .baseByte(baseByte), .memBase(memBase),
    .st(st), .prioOut(prioOut), .ack(ack), .romAddr(romAddr)
  );

  slot_enum_dp #(
    .DATA_W(DATA_W), .BASE_W(BASE_W), .MB_W(MB_W), .ID_CODE(ID_CODE)
  ) dp_i (
    .clk(clk), .rstN(rstN), .st(st), .wrData(wrData), .romData(romData),
    .baseByte(baseByte), .memBase(memBase), .rdData(rdData)
  );

endmodule

// File: tb/chain_slot_decoder_tb_top.sv
module chain_slot_decoder_tb_top;
  localparam logic [15:0] ID = 16'h0A5C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        prioIn = 1'b0;
  logic        ioRd = 1'b0, ioWr = 1'b0, memRd = 1'b0, memWr = 1'b0;
  logic [23:0] addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData, romData;
  logic        ack, prioOut;
  logic [11:0] romAddr;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic        ack;
    logic [15:0] data;
    string       tag;
  } exp_t;
  exp_t expQ[$];

  always #4 clk = ~clk;

  // ROM model: pattern of the word address
  assign romData = {4'hA, romAddr} ^ 16'h1234;

  chain_slot_decoder dut_i (
    .clk(clk), .rstN(rstN), .prioIn(prioIn), .prioOut(prioOut),
    .ioRd(ioRd), .ioWr(ioWr), .memRd(memRd), .memWr(memWr),
    .addr(addr), .wrData(wrData), .rdData(rdData), .ack(ack),
    .romAddr(romAddr), .romData(romData)
  );

  function automatic logic [15:0] romWord(input logic [23:0] a);
    return {4'hA, a[12:1]} ^ 16'h1234;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: compare each queued expectation one step after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        check({e.tag, " ack"}, {31'd0, ack}, {31'd0, e.ack});
        check({e.tag, " data"}, {16'd0, rdData}, {16'd0, e.data});
      end
    end
  end

  // Driver: one strobe for one cycle, expectation pushed alongside
  task automatic busOp(input int kind, input logic [23:0] a, input logic [15:0] d,
                       input logic eAck, input logic [15:0] eData, input string tag);
    exp_t e;
    @(negedge clk);
    addr = a; wrData = d;
    ioRd = (kind == 0); ioWr = (kind == 1); memRd = (kind == 2); memWr = (kind == 3);
    e.ack = eAck; e.data = eData; e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
    ioRd = 1'b0; ioWr = 1'b0; memRd = 1'b0; memWr = 1'b0;
  endtask

  task automatic idleExp(input string tag);
    exp_t e;
    e.ack = 1'b0; e.data = '0; e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset prioOut", {31'd0, prioOut}, 0);
    check("R1 reset ack", {31'd0, ack}, 0);
    check("R1 reset rdData", {16'd0, rdData}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: no priority, no answer
    busOp(0, 24'h000000, 0, 1'b0, 16'h0, "R2 id read without priority");
    check("R2 prioOut low", {31'd0, prioOut}, 0);

    prioIn = 1'b1;
    @(negedge clk);
    busOp(2, 24'h012346, 0, 1'b0, 16'h0, "R10 mem read unconfigured");
    busOp(0, 24'h003720, 0, 1'b0, 16'h0, "R10 io read unconfigured");
    busOp(0, 24'h000000, 0, 1'b1, ID, "R3 id read");
    check("R3 prioOut still low", {31'd0, prioOut}, 0);
    busOp(1, 24'h000000, 16'hAB37, 1'b1, 16'h0, "R4 base write");
    check("R4 prioOut released", {31'd0, prioOut}, 1);

    busOp(0, 24'h000000, 0, 1'b0, 16'h0, "R5 id no longer answered");
    busOp(0, 24'h003820, 0, 1'b0, 16'h0, "R5 neighbour window");
    busOp(0, 24'h003700, 0, 1'b1, 16'h0, "R9 other offset reads zero");
    busOp(1, 24'h003720, 16'hFFF5, 1'b1, 16'h0, "R6 map write");
    busOp(0, 24'h003720, 0, 1'b1, 16'h0005, "R6 map read");

    busOp(2, 24'h5ABCDE, 0, 1'b1, romWord(24'h5ABCDE), "R7 rom read a");
    busOp(2, 24'h500002, 0, 1'b1, romWord(24'h500002), "R7 rom read b");
    busOp(2, 24'h6ABCDE, 0, 1'b0, 16'h0, "R7 other megabyte");

    busOp(3, 24'h5ABCDE, 16'h0003, 1'b0, 16'h0, "R8 mem write ignored");
    busOp(3, 24'h500000, 16'h0009, 1'b0, 16'h0, "R8 second mem write");
    busOp(0, 24'h003720, 0, 1'b1, 16'h0005, "R8 map unchanged");

    idleExp("R9 idle after read");
    busOp(2, 24'h500010, 0, 1'b1, romWord(24'h500010), "R9 pulse a");
    idleExp("R9 ack drops");

    // R2: one cycle of lost priority
    @(negedge clk);
    prioIn = 1'b0;
    #1;
    check("R2 prioOut follows prioIn", {31'd0, prioOut}, 0);
    @(negedge clk);
    prioIn = 1'b1;
    @(negedge clk);
    check("R2 still unconfigured", {31'd0, prioOut}, 0);
    busOp(0, 24'h003720, 0, 1'b0, 16'h0, "R2 old window gone");
    busOp(2, 24'h000000, 0, 1'b0, 16'h0, "R2 rom map gone");
    busOp(0, 24'h000000, 0, 1'b1, ID, "R2 id answered again");
    busOp(1, 24'h000000, 16'h0012, 1'b1, 16'h0, "R4 second base write");
    check("R4 prioOut released again", {31'd0, prioOut}, 1);
    busOp(0, 24'h001220, 0, 1'b1, 16'h0000, "R5 new window");

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule